// File: doc/BRIEF.md
# Hotplug General-Purpose Event Register Block

This block holds the event status and event enable bits that firmware polls when a slot is hot-inserted or hot-removed. It also holds the two slot bitmaps that say which slot changed, and an eject port through which software names a slot to power down. The event status and enable registers are 16 bits each and are reached one byte at a time through a small byte window. The two 32-bit bitmaps sit in a separate word window, and the eject port takes a full word.

A hotplug event arrives on a one-cycle valid input with a slot index and an insert/remove flag. The event wipes both bitmaps and marks the one slot in the bitmap for its direction. It sets the hotplug status bit and, when the matching enable bit is on, emits a one-cycle interrupt pulse that the surrounding chip ORs into its shared system-control interrupt. A write to the eject port is priority-encoded to the lowest set bit. The block then puts out that index with a one-cycle strobe that the slot power logic uses.

Top module: `hotplug_gpe`

## Requirements
- R1: After a synchronous active-low reset all four event bytes read 0, both bitmaps read 0, and `sci_pulse` and `ej_strobe` are low.
- R2: A write to byte offset 0 (status bits 7..0) or offset 1 (status bits 15..8) clears the status bits written as 1 in that byte only, and leaves the other status byte unchanged.
- R3: A write to byte offset 2 (enable bits 7..0) or offset 3 (enable bits 15..8) replaces that enable byte and keeps the other enable byte.
- R4: The slot bitmaps are read/write words: `slot_sel`=0 selects the up (inserted) bitmap and `slot_sel`=1 selects the down (removed) bitmap, for both `slot_wdata` writes and `slot_rdata` reads.
- R5: A hotplug event clears both bitmaps. It then sets bit `hp_slot` of the up bitmap when `hp_insert`=1, or of the down bitmap when `hp_insert`=0. An event takes priority over a bitmap write in the same cycle.
- R6: Every hotplug event sets status bit 1. The set wins over a clear of that bit written in the same cycle.
- R7: `sci_pulse` is high for exactly the one cycle after an event, and only when enable bit 1 was set in the cycle of the event.
- R8: A write of a nonzero value to the eject port makes `ej_strobe` high for the following cycle, with `ej_slot` equal to the index of the lowest set bit of the written value.
- R9: A write of 0 to the eject port produces no strobe and leaves `ej_slot` unchanged.
- R10: `ej_rdata` always reads 0.
- R11: `gpe_rdata` returns, without delay, the byte selected by `gpe_addr`: offset 0 status low, 1 status high, 2 enable low, 3 enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpe_wr | input | 1 | Byte write strobe for the event window |
| gpe_addr | input | 2 | Byte offset in the event window |
| gpe_wdata | input | 8 | Byte write data |
| gpe_rdata | output | 8 | Byte read data for `gpe_addr` |
| slot_wr | input | 1 | Bitmap write strobe |
| slot_sel | input | 1 | 0 = up bitmap, 1 = down bitmap |
| slot_wdata | input | 32 | Bitmap write data |
| slot_rdata | output | 32 | Selected bitmap |
| hp_valid | input | 1 | One-cycle hotplug event |
| hp_slot | input | 5 | Slot index of the event |
| hp_insert | input | 1 | 1 = insert, 0 = removal |
| ej_wr | input | 1 | Eject port write strobe |
| ej_wdata | input | 32 | Eject port write data |
| ej_rdata | output | 32 | Eject port read data (always 0) |
| ej_strobe | output | 1 | One-cycle removal request |
| ej_slot | output | 5 | Slot index to remove |
| sci_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
Hotplug events are swept over every slot in both directions, once with enable bit 1 off and once with it on. This separates a wrong bitmap side or bit position from a missing or stuck interrupt pulse. The bitmaps are preloaded with dense patterns before the events, which shows whether an event really clears the stale bits. The eject port is driven with every lowest-bit position under busy upper bits and with zero, which exposes an encoder that picks the wrong end or strobes on an empty write. The byte-lane writes use clears and replaces that differ per lane, which catches a write that leaks into the neighbouring byte.

// File: rtl/hpgpe_pkg.sv
// Package hpgpe_pkg
// Shared constants for the hotplug event register block.
// Assumes byte-wide access to the event window.
package hpgpe_pkg;
    localparam int BYTE_W = 8;
    // Bitmap selector encoding on the slot window
    localparam logic SEL_UP   = 1'b0;
    localparam logic SEL_DOWN = 1'b1;
endpackage

// File: rtl/hpgpe_gpe_regs.sv
// Module hpgpe_gpe_regs
// Event status (write-1-to-clear per byte) and event enable (direct byte
// write) registers, plus the combinational byte read mux.
// Assumes GPE_BITS is a multiple of 8; status bytes come first in the window,
// enable bytes follow. A hotplug set wins over a same-cycle clear.
module hpgpe_gpe_regs
    import hpgpe_pkg::*;
#(
    parameter int GPE_BITS = 16,
    parameter int HP_BIT   = 1,
    localparam int BYTES   = GPE_BITS / BYTE_W,
    localparam int AW      = $clog2(2 * BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [AW-1:0]       addr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                hp_set,
    output logic [GPE_BITS-1:0] status,
    output logic [GPE_BITS-1:0] enable,
    output logic [BYTE_W-1:0]   rdata
);
    localparam logic [GPE_BITS-1:0] HP_MASK = GPE_BITS'(1) << HP_BIT;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] st_q;
        logic [BYTE_W-1:0] en_q;
        logic [BYTE_W-1:0] set_mask;
        logic              hit_st;
        logic              hit_en;

        assign hit_st   = wr && (addr == AW'(b));
        assign hit_en   = wr && (addr == AW'(BYTES + b));
        assign set_mask = hp_set ? HP_MASK[b*BYTE_W +: BYTE_W] : '0;

        // Status lane: clear written ones, then OR in the event bit
        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= (hit_st ? (st_q & ~wdata) : st_q) | set_mask;
        end

        // Enable lane: take the written byte
        always_ff @(posedge clk) begin
            if (!rst_n)      en_q <= '0;
            else if (hit_en) en_q <= wdata;
        end

        assign status[b*BYTE_W +: BYTE_W] = st_q;
        assign enable[b*BYTE_W +: BYTE_W] = en_q;
    end

    // Read mux: pick the addressed byte
    always_comb begin
        rdata = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (addr == AW'(i))         rdata = status[i*BYTE_W +: BYTE_W];
            if (addr == AW'(BYTES + i)) rdata = enable[i*BYTE_W +: BYTE_W];
        end
    end

    // R2: clearing the low status byte touches only the written ones
    p_w1c_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && $past(addr) == AW'(0) && !$past(hp_set))
        |-> (status[BYTE_W-1:0] == ($past(status[BYTE_W-1:0]) & ~$past(wdata))));

    // R2: a low-byte clear leaves the high status byte alone
    p_w1c_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && $past(addr) == AW'(0) && !$past(hp_set))
        |-> (status[GPE_BITS-1:BYTE_W] == $past(status[GPE_BITS-1:BYTE_W])));

    // R3: low enable write replaces its byte and keeps the other
    p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && $past(addr) == AW'(BYTES))
        |-> (enable[BYTE_W-1:0] == $past(wdata)
             && enable[GPE_BITS-1:BYTE_W] == $past(enable[GPE_BITS-1:BYTE_W])));

    // R6: an event always leaves the hotplug status bit set
    p_hp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hp_set)) |-> status[HP_BIT]);
endmodule

// File: rtl/hpgpe_slot_maps.sv
// Module hpgpe_slot_maps
// Slot-up and slot-down bitmaps. Software may read and write either word;
// a hotplug event replaces both with a single marked bit.
// Assumes at most one event per cycle; an event beats a software write.
module hpgpe_slot_maps
    import hpgpe_pkg::*;
#(
    parameter int  NUM_SLOTS = 32,
    localparam int SW        = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 sel,
    input  logic [NUM_SLOTS-1:0] wdata,
    input  logic                 hp_valid,
    input  logic [SW-1:0]        hp_slot,
    input  logic                 hp_insert,
    output logic [NUM_SLOTS-1:0] rdata
);
    logic [NUM_SLOTS-1:0] up_q;
    logic [NUM_SLOTS-1:0] down_q;
    logic [NUM_SLOTS-1:0] onehot;

    assign onehot = NUM_SLOTS'(1) << hp_slot;

    // Bitmap update: event replaces both, otherwise a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q   <= '0;
            down_q <= '0;
        end else if (hp_valid) begin
            up_q   <= hp_insert ? onehot : '0;
            down_q <= hp_insert ? '0 : onehot;
        end else if (wr) begin
            if (sel == SEL_DOWN) down_q <= wdata;
            else                 up_q   <= wdata;
        end
    end

    // Read select
    assign rdata = (sel == SEL_DOWN) ? down_q : up_q;

    // R5: after an event exactly one bit is set across both maps
    p_event_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hp_valid))
        |-> (($countones(up_q) + $countones(down_q)) == 1));

    // R5: an insert leaves the down map empty
    p_event_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hp_valid) && $past(hp_insert)) |-> (down_q == '0));

    // R4: an up-map write without an event is stored as written
    p_slot_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr) && !$past(hp_valid) && $past(sel) == SEL_UP)
        |-> (up_q == $past(wdata)));
endmodule

// File: rtl/hpgpe_eject.sv
// Module hpgpe_eject
// Eject port: priority-encodes the lowest set bit of a written word and
// registers it with a one-cycle strobe. A zero write is dropped.
// Assumes the consumer samples ej_slot only while the strobe is high.
module hpgpe_eject #(
    parameter int  NUM_SLOTS = 32,
    localparam int SW        = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [NUM_SLOTS-1:0] wdata,
    output logic                 strobe,
    output logic [SW-1:0]        slot
);
    logic [SW-1:0] low_idx;
    logic          any_set;

    // Priority encoder: scan from the top so the lowest set bit wins
    always_comb begin
        low_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (wdata[i]) low_idx = SW'(i);
        end
    end

    assign any_set = |wdata;

    // Strobe and slot register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            slot   <= '0;
        end else begin
            strobe <= wr && any_set;
            if (wr && any_set) slot <= low_idx;
        end
    end

    // R9: a strobe only follows a nonzero write
    p_eject_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> ($past(rst_n) && $past(wr) && $past(wdata) != '0));

    // R8: the reported slot is set in the word and nothing below it is
    p_eject_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> ((($past(wdata) >> slot) & NUM_SLOTS'(1)) != '0
                    && ($past(wdata) & ~({NUM_SLOTS{1'b1}} << slot)) == '0));
endmodule

// File: rtl/hotplug_gpe.sv
// Module hotplug_gpe
// Top of the hotplug event register block: event status/enable byte window,
// slot bitmaps, eject port and the one-cycle interrupt pulse.
// Assumes hp_valid is a single-cycle event; sci_pulse is ORed outside.
module hotplug_gpe
    import hpgpe_pkg::*;
#(
    parameter int  GPE_BITS  = 16,
    parameter int  HP_BIT    = 1,
    parameter int  NUM_SLOTS = 32,
    localparam int GPE_AW    = $clog2(2 * (GPE_BITS / BYTE_W)),
    localparam int SW        = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gpe_wr,
    input  logic [GPE_AW-1:0]    gpe_addr,
    input  logic [BYTE_W-1:0]    gpe_wdata,
    output logic [BYTE_W-1:0]    gpe_rdata,
    input  logic                 slot_wr,
    input  logic                 slot_sel,
    input  logic [NUM_SLOTS-1:0] slot_wdata,
    output logic [NUM_SLOTS-1:0] slot_rdata,
    input  logic                 hp_valid,
    input  logic [SW-1:0]        hp_slot,
    input  logic                 hp_insert,
    input  logic                 ej_wr,
    input  logic [NUM_SLOTS-1:0] ej_wdata,
    output logic [NUM_SLOTS-1:0] ej_rdata,
    output logic                 ej_strobe,
    output logic [SW-1:0]        ej_slot,
    output logic                 sci_pulse
);
    logic [GPE_BITS-1:0] gpe_status;
    logic [GPE_BITS-1:0] gpe_enable;

    hpgpe_gpe_regs #(.GPE_BITS(GPE_BITS), .HP_BIT(HP_BIT)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (gpe_wr),
        .addr   (gpe_addr),
        .wdata  (gpe_wdata),
        .hp_set (hp_valid),
        .status (gpe_status),
        .enable (gpe_enable),
        .rdata  (gpe_rdata)
    );

    hpgpe_slot_maps #(.NUM_SLOTS(NUM_SLOTS)) u_maps (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (slot_wr),
        .sel       (slot_sel),
        .wdata     (slot_wdata),
        .hp_valid  (hp_valid),
        .hp_slot   (hp_slot),
        .hp_insert (hp_insert),
        .rdata     (slot_rdata)
    );

    hpgpe_eject #(.NUM_SLOTS(NUM_SLOTS)) u_eject (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ej_wr),
        .wdata  (ej_wdata),
        .strobe (ej_strobe),
        .slot   (ej_slot)
    );

    // The eject port has nothing to read back
    assign ej_rdata = '0;

    // Interrupt pulse: one cycle after an enabled event
    always_ff @(posedge clk) begin
        if (!rst_n) sci_pulse <= 1'b0;
        else        sci_pulse <= hp_valid && gpe_enable[HP_BIT];
    end

    // R7: a pulse always traces back to an enabled event
    p_sci_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sci_pulse |-> ($past(rst_n) && $past(hp_valid) && $past(gpe_enable[HP_BIT])));

    // R7: an enabled event is never missed
    p_sci_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hp_valid) && $past(gpe_enable[HP_BIT])) |-> sci_pulse);

    // R6: status bit set after any event, seen at the top
    p_status_after_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hp_valid)) |-> gpe_status[HP_BIT]);
endmodule

// File: tb/hotplug_gpe_bench.sv
`timescale 1ns/1ps
module hotplug_gpe_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        gpe_wr;
    logic [1:0]  gpe_addr;
    logic [7:0]  gpe_wdata;
    logic [7:0]  gpe_rdata;
    logic        slot_wr;
    logic        slot_sel;
    logic [31:0] slot_wdata;
    logic [31:0] slot_rdata;
    logic        hp_valid;
    logic [4:0]  hp_slot;
    logic        hp_insert;
    logic        ej_wr;
    logic [31:0] ej_wdata;
    logic [31:0] ej_rdata;
    logic        ej_strobe;
    logic [4:0]  ej_slot;
    logic        sci_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_st;
    logic [15:0] exp_en;

    always #10 clk = ~clk;

    hotplug_gpe u_hotplug_gpe (
        .clk(clk), .rst_n(rst_n),
        .gpe_wr(gpe_wr), .gpe_addr(gpe_addr), .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata),
        .slot_wr(slot_wr), .slot_sel(slot_sel), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata),
        .hp_valid(hp_valid), .hp_slot(hp_slot), .hp_insert(hp_insert),
        .ej_wr(ej_wr), .ej_wdata(ej_wdata), .ej_rdata(ej_rdata),
        .ej_strobe(ej_strobe), .ej_slot(ej_slot), .sci_pulse(sci_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic gpe_read(input logic [1:0] a, output logic [7:0] v);
        gpe_addr = a;
        #1;
        v = gpe_rdata;
    endtask

    task automatic slot_read(input logic s, output logic [31:0] v);
        slot_sel = s;
        #1;
        v = slot_rdata;
    endtask

    task automatic gpe_write(input logic [1:0] a, input logic [7:0] d);
        gpe_addr = a; gpe_wdata = d; gpe_wr = 1'b1;
        @(negedge clk);
        gpe_wr = 1'b0;
    endtask

    task automatic check_gpe(input string tag);
        logic [7:0] v;
        gpe_read(2'd0, v); chk(tag, {24'd0, v}, {24'd0, exp_st[7:0]});
        gpe_read(2'd1, v); chk(tag, {24'd0, v}, {24'd0, exp_st[15:8]});
        gpe_read(2'd2, v); chk(tag, {24'd0, v}, {24'd0, exp_en[7:0]});
        gpe_read(2'd3, v); chk(tag, {24'd0, v}, {24'd0, exp_en[15:8]});
    endtask

    initial begin
        logic [31:0] w;
        logic [7:0]  b;
        rst_n = 1'b0; gpe_wr = 0; gpe_addr = 0; gpe_wdata = 0;
        slot_wr = 0; slot_sel = 0; slot_wdata = 0;
        hp_valid = 0; hp_slot = 0; hp_insert = 0; ej_wr = 0; ej_wdata = 0;
        exp_st = 16'h0; exp_en = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_gpe("R1 event bytes");
        slot_read(1'b0, w); chk("R1 up map", w, 32'h0);
        slot_read(1'b1, w); chk("R1 down map", w, 32'h0);
        chk("R1 sci", {31'd0, sci_pulse}, 32'h0);
        chk("R1 strobe", {31'd0, ej_strobe}, 32'h0);
        chk("R10 eject read", ej_rdata, 32'h0);

        // R3 / R11: enable byte writes, each lane separately
        for (int k = 0; k < 16; k++) begin
            b = 8'(k * 17 + 3);
            gpe_write(2'd2, b); exp_en[7:0] = b;
            check_gpe("R3 enable low lane");
            gpe_write(2'd3, ~b); exp_en[15:8] = ~b;
            check_gpe("R3 enable high lane");
        end
        gpe_write(2'd3, 8'h00); exp_en[15:8] = 8'h00;
        check_gpe("R11 read mux");

        // R4: bitmap write and read back
        slot_sel = 1'b0; slot_wdata = 32'hA5A5_0F0F; slot_wr = 1'b1;
        @(negedge clk);
        slot_sel = 1'b1; slot_wdata = 32'h1234_5678;
        @(negedge clk);
        slot_wr = 1'b0;
        slot_read(1'b0, w); chk("R4 up map", w, 32'hA5A5_0F0F);
        slot_read(1'b1, w); chk("R4 down map", w, 32'h1234_5678);

        // R2: status clears per byte
        hp_valid = 1'b1; hp_slot = 5'd3; hp_insert = 1'b1;
        @(negedge clk);
        hp_valid = 1'b0; exp_st = 16'h0002;
        @(negedge clk);
        gpe_write(2'd1, 8'hFF); check_gpe("R2 other byte kept");
        gpe_write(2'd0, 8'hFD); check_gpe("R2 zero bits kept");
        gpe_write(2'd0, 8'h02); exp_st = 16'h0; check_gpe("R2 clear");

        // R6: event wins over a same-cycle clear
        gpe_addr = 2'd0; gpe_wdata = 8'hFF; gpe_wr = 1'b1;
        hp_valid = 1'b1; hp_slot = 5'd9; hp_insert = 1'b0;
        @(negedge clk);
        gpe_wr = 1'b0; hp_valid = 1'b0; exp_st = 16'h0002;
        check_gpe("R6 set beats clear");
        gpe_write(2'd0, 8'h02); exp_st = 16'h0;

        // R5 / R6 / R7: sweep every slot, both directions, enable off and on
        for (int en_on = 0; en_on < 2; en_on++) begin
            gpe_write(2'd2, en_on != 0 ? 8'h02 : 8'hFD);
            exp_en[7:0] = en_on != 0 ? 8'h02 : 8'hFD;
            for (int s = 0; s < 32; s++) begin
                for (int ins = 0; ins < 2; ins++) begin
                    // preload dense stale maps so the clear is visible
                    slot_sel = ins[0]; slot_wdata = 32'hFFFF_FFFF; slot_wr = 1'b1;
                    @(negedge clk);
                    slot_wr = 1'b0;
                    hp_valid = 1'b1; hp_slot = 5'(s); hp_insert = ins[0];
                    @(negedge clk);
                    hp_valid = 1'b0;
                    chk("R7 pulse level", {31'd0, sci_pulse}, {31'd0, en_on[0]});
                    slot_read(1'b0, w);
                    chk("R5 up map", w, ins != 0 ? (32'h1 << s) : 32'h0);
                    slot_read(1'b1, w);
                    chk("R5 down map", w, ins != 0 ? 32'h0 : (32'h1 << s));
                    exp_st = 16'h0002;
                    check_gpe("R6 status set");
                    @(negedge clk);
                    chk("R7 pulse one cycle", {31'd0, sci_pulse}, 32'h0);
                    gpe_write(2'd0, 8'h02); exp_st = 16'h0;
                end
            end
        end

        // R8: every lowest-bit position under busy upper bits
        for (int i = 0; i < 32; i++) begin
            logic [63:0] m;
            m = (64'h1 << (i + 1)) - 64'h1;
            ej_wdata = (32'h1 << i) | (32'hDEAD_BEEF & ~m[31:0]);
            ej_wr = 1'b1;
            @(negedge clk);
            ej_wr = 1'b0;
            chk("R8 strobe", {31'd0, ej_strobe}, 32'h1);
            chk("R8 slot", {27'd0, ej_slot}, 32'(i));
            chk("R10 eject read", ej_rdata, 32'h0);
            @(negedge clk);
            chk("R8 strobe drops", {31'd0, ej_strobe}, 32'h0);
        end

        // R9: zero write gives no strobe, slot held at last value 31
        ej_wdata = 32'h0; ej_wr = 1'b1;
        @(negedge clk);
        ej_wr = 1'b0;
        chk("R9 no strobe", {31'd0, ej_strobe}, 32'h0);
        chk("R9 slot held", {27'd0, ej_slot}, 32'd31);
        @(negedge clk);
        chk("R9 still no strobe", {31'd0, ej_strobe}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule